// File: doc/BRIEF.md
# Quota-Aware Replacement Victim Selector

This block decides which line of one set of a shared set-associative cache is replaced when a core misses, so that each core stays within a per-core limit on the number of ways it holds. The tag array supplies the set's metadata: a valid bit, the id of the core that filled the line, and an age rank for every way. Age 0 is the most recently used line and larger values are older. The block receives the requesting core's id, whether the access hit, and a table of per-core way quotas.

On a miss, an empty way is taken first. If every way holds a line, the block counts the requester's lines in the set. When that count is still under the requester's quota, the requester takes the oldest line belonging to some other core. Once the quota is reached, the requester has to recycle its own oldest line. The block also returns the metadata to write back: the filled way gets the requester's id and becomes the most recent line, and the lines younger than the accessed one each move one step older. A hit uses the same age update and leaves every owner field as it was. The whole result is combinational and is produced in the cycle of the access.

Top module: `wp_victim_sel`

## Requirements
- R1: While `req_valid` is 0, `upd_valid`, `upd_owner` and `upd_age` are equal to `way_valid`, `way_owner` and `way_age`.
- R2: On a miss (`req_valid`=1, `req_hit`=0) with at least one bit of `way_valid` clear, `victim_way` is the lowest-numbered invalid way, whatever the owners and quotas are.
- R3: On a miss with all ways valid, where the number of ways whose owner field (`way_owner[w*CIDW +: CIDW]`) equals `req_core` is less than the requester's quota (`core_quota[c*QW +: QW]` for core c), `victim_way` is the way with the largest `way_age[w*AW +: AW]` among the lines owned by other cores.
- R4: On a miss with all ways valid, where the requester's line count is greater than or equal to its quota, `victim_way` is the way with the largest age among the requester's own lines.
- R5: If the group selected by R3 or R4 contains no lines, `victim_way` is the way with the largest age in the whole set.
- R6: On a miss, the victim way returns with valid set, owner equal to `req_core` and age 0. The valid bits and owners of all other ways pass through unchanged.
- R7: On any access, each way other than the accessed one whose age is less than the accessed way's old age leaves with that age plus one. Every other way keeps its age, and the accessed way leaves with age 0.
- R8: On a hit (`req_valid`=1, `req_hit`=1), `victim_way` equals `hit_way`, the accessed way is `hit_way`, and `upd_owner` and `upd_valid` equal their inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_valid | input | 1 | An access to this set is presented this cycle |
| req_hit | input | 1 | The access hit in `hit_way` |
| hit_way | input | AW | Way that hit |
| req_core | input | CIDW | Id of the requesting core |
| way_valid | input | WAYS | Valid bit of each way |
| way_owner | input | WAYS*CIDW | Owner core id of each way, way w at bits w*CIDW |
| way_age | input | WAYS*AW | Age rank of each way, 0 = most recent |
| core_quota | input | CORES*QW | Way quota of each core, core c at bits c*QW |
| victim_way | output | AW | Way to replace on a miss, or `hit_way` on a hit |
| upd_valid | output | WAYS | Valid bits to write back |
| upd_owner | output | WAYS*CIDW | Owner fields to write back |
| upd_age | output | WAYS*AW | Age ranks to write back |

## Verification
Two kinds of event can land in the same miss cycle. The empty-way priority can override the quota rule, and the fallback can replace the group that the quota comparison picked. Each also meets the fill and aging update in that cycle. Vectors are built so that the quota rule, taken alone, would point at a different way than the one expected. This happens when an invalid way sits among lines the requester would otherwise give up, and when the selected group is empty. The bench then judges the chosen way together with the full written-back owner, valid and age vectors, which it computes from its own model of the rules.

// File: rtl/wp_pkg.sv
package wp_pkg;
  // Which candidate set the miss victim was drawn from.
  typedef enum logic [1:0] {
    GRP_FREE  = 2'd0,
    GRP_OTHER = 2'd1,
    GRP_OWN   = 2'd2,
    GRP_ANY   = 2'd3
  } grp_e;
endpackage

// File: rtl/wp_occupancy.sv
module wp_occupancy #(
  parameter int WAYS  = 16,
  parameter int CORES = 4,
  parameter int CIDW  = 2,
  parameter int QW    = 5
) (
  input  logic [WAYS-1:0]       way_valid,
  input  logic [WAYS*CIDW-1:0]  way_owner,
  input  logic [CIDW-1:0]       req_core,
  input  logic [CORES*QW-1:0]   core_quota,
  output logic [WAYS-1:0]       own_mask,
  output logic [WAYS-1:0]       other_mask,
  output logic                  quota_met
);

  function automatic logic [QW-1:0] pop_count(input logic [WAYS-1:0] m);
    logic [QW-1:0] n;
    n = '0;
    for (int i = 0; i < WAYS; i++) n = n + QW'(m[i]);
    return n;
  endfunction

  function automatic logic [QW-1:0] quota_of(input logic [CORES*QW-1:0] tbl,
                                             input logic [CIDW-1:0] c);
    logic [QW-1:0] q;
    q = '0;
    for (int k = 0; k < CORES; k++)
      if (CIDW'(k) == c) q = tbl[k*QW +: QW];
    return q;
  endfunction

  logic [QW-1:0] own_count;
  logic [QW-1:0] req_quota;

  for (genvar w = 0; w < WAYS; w++) begin : g_mask
    logic mine;
    assign mine          = (way_owner[w*CIDW +: CIDW] == req_core);
    assign own_mask[w]   = way_valid[w] &&  mine;
    assign other_mask[w] = way_valid[w] && !mine;
  end

  assign own_count = pop_count(own_mask);
  assign req_quota = quota_of(core_quota, req_core);
  assign quota_met = (own_count >= req_quota);

  // R3 R4: the two candidate groups split the valid lines with no overlap.
  always_comb begin
    p_groups_split_r3: assert (((own_mask & other_mask) == '0) &&
                               ((own_mask | other_mask) == way_valid))
      else $error("own/other groups do not partition the valid lines");
  end

endmodule

// File: rtl/wp_oldest_pick.sv
module wp_oldest_pick #(
  parameter int WAYS = 16,
  parameter int AW   = 4
) (
  input  logic [WAYS-1:0]    mask,
  input  logic [WAYS*AW-1:0] way_age,
  output logic [AW-1:0]      pick_way,
  output logic               pick_any
);

  function automatic logic [AW-1:0] age_at(input logic [WAYS*AW-1:0] ages,
                                           input logic [AW-1:0] w);
    logic [AW-1:0] a;
    a = '0;
    for (int i = 0; i < WAYS; i++)
      if (AW'(i) == w) a = ages[i*AW +: AW];
    return a;
  endfunction

  logic [AW-1:0] best_age;

  // Linear scan: strictly greater age wins, so ties keep the lower index.
  always_comb begin
    pick_way = '0;
    pick_any = 1'b0;
    best_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (mask[w] && (!pick_any || (way_age[w*AW +: AW] > best_age))) begin
        pick_way = AW'(w);
        best_age = way_age[w*AW +: AW];
        pick_any = 1'b1;
      end
    end
  end

  // R3 R4 R5: the picked way is a member and no member is older.
  always_comb begin
    p_pick_member_r5: assert (!pick_any || mask[pick_way])
      else $error("picked way is outside its candidate mask");
    p_pick_present_r5: assert (pick_any == (mask != '0))
      else $error("pick flag disagrees with mask");
    for (int w = 0; w < WAYS; w++) begin
      p_pick_oldest_r3: assert (!(pick_any && mask[w]) ||
                                (way_age[w*AW +: AW] <= age_at(way_age, pick_way)))
        else $error("a candidate is older than the picked way");
    end
  end

endmodule

// File: rtl/wp_lru_update.sv
module wp_lru_update #(
  parameter int WAYS = 16,
  parameter int CIDW = 2,
  parameter int AW   = 4
) (
  input  logic                 do_access,
  input  logic                 do_fill,
  input  logic [AW-1:0]        acc_way,
  input  logic [CIDW-1:0]      req_core,
  input  logic [WAYS-1:0]      way_valid,
  input  logic [WAYS*CIDW-1:0] way_owner,
  input  logic [WAYS*AW-1:0]   way_age,
  output logic [WAYS-1:0]      upd_valid,
  output logic [WAYS*CIDW-1:0] upd_owner,
  output logic [WAYS*AW-1:0]   upd_age
);

  // Age after an access: the accessed way becomes 0, younger ones step older.
  function automatic logic [AW-1:0] next_age(input logic [AW-1:0] age,
                                             input logic [AW-1:0] ref_age,
                                             input logic          is_acc);
    if (is_acc)           return '0;
    if (age < ref_age)    return age + AW'(1);
    return age;
  endfunction

  logic [AW-1:0] acc_age;

  always_comb begin
    acc_age = '0;
    for (int i = 0; i < WAYS; i++)
      if (AW'(i) == acc_way) acc_age = way_age[i*AW +: AW];
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic hit_me;
    logic fill_me;
    assign hit_me  = do_access && (acc_way == AW'(w));
    assign fill_me = do_fill   && hit_me;
    assign upd_valid[w]                = way_valid[w] | fill_me;
    assign upd_owner[w*CIDW +: CIDW]   = fill_me ? req_core : way_owner[w*CIDW +: CIDW];
    assign upd_age[w*AW +: AW]         = do_access ?
                                         next_age(way_age[w*AW +: AW], acc_age, hit_me) :
                                         way_age[w*AW +: AW];
  end

  always_comb begin
    p_idle_hold_r1: assert (do_access || ((upd_age == way_age) &&
                                          (upd_owner == way_owner) &&
                                          (upd_valid == way_valid)))
      else $error("metadata changed without an access");
    p_owner_kept_r8: assert (!(do_access && !do_fill) ||
                             ((upd_owner == way_owner) && (upd_valid == way_valid)))
      else $error("hit changed ownership or validity");
    for (int w = 0; w < WAYS; w++) begin
      p_mru_zero_r6: assert (!(do_access && (acc_way == AW'(w))) ||
                             (upd_age[w*AW +: AW] == '0))
        else $error("accessed way did not become most recent");
      p_age_bound_r7: assert (!do_access || (acc_way == AW'(w)) ||
                              (upd_age[w*AW +: AW] >= way_age[w*AW +: AW]))
        else $error("a non-accessed way became younger");
    end
  end

endmodule

// File: rtl/wp_victim_sel.sv
module wp_victim_sel #(
  parameter int WAYS  = 16,
  parameter int CORES = 4,
  localparam int CIDW = (CORES > 1) ? $clog2(CORES) : 1,
  localparam int AW   = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int QW   = $clog2(WAYS + 1)
) (
  input  logic                 req_valid,
  input  logic                 req_hit,
  input  logic [AW-1:0]        hit_way,
  input  logic [CIDW-1:0]      req_core,
  input  logic [WAYS-1:0]      way_valid,
  input  logic [WAYS*CIDW-1:0] way_owner,
  input  logic [WAYS*AW-1:0]   way_age,
  input  logic [CORES*QW-1:0]  core_quota,
  output logic [AW-1:0]        victim_way,
  output logic [WAYS-1:0]      upd_valid,
  output logic [WAYS*CIDW-1:0] upd_owner,
  output logic [WAYS*AW-1:0]   upd_age
);
  import wp_pkg::*;

  localparam int NPICK = 3;  // 0: own lines, 1: other cores' lines, 2: all lines

  // Lowest-numbered empty way, with a found flag on top.
  function automatic logic [AW:0] first_free(input logic [WAYS-1:0] v);
    logic [AW:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!v[i]) r = {1'b1, AW'(i)};
    return r;
  endfunction

  function automatic logic [CIDW-1:0] owner_of(input logic [WAYS*CIDW-1:0] own,
                                               input logic [AW-1:0] w);
    logic [CIDW-1:0] c;
    c = '0;
    for (int i = 0; i < WAYS; i++)
      if (AW'(i) == w) c = own[i*CIDW +: CIDW];
    return c;
  endfunction

  logic [WAYS-1:0] own_mask;
  logic [WAYS-1:0] other_mask;
  logic            quota_met;
  logic            free_any;
  logic [AW-1:0]   free_way;
  logic [WAYS-1:0] pick_mask [NPICK];
  logic [AW-1:0]   pick_way  [NPICK];
  logic            pick_any  [NPICK];
  grp_e            grp;
  logic [AW-1:0]   miss_way;
  logic            do_fill;

  wp_occupancy #(
    .WAYS(WAYS), .CORES(CORES), .CIDW(CIDW), .QW(QW)
  ) u_occ (
    .way_valid  (way_valid),
    .way_owner  (way_owner),
    .req_core   (req_core),
    .core_quota (core_quota),
    .own_mask   (own_mask),
    .other_mask (other_mask),
    .quota_met  (quota_met)
  );

  assign pick_mask[0] = own_mask;
  assign pick_mask[1] = other_mask;
  assign pick_mask[2] = way_valid;

  for (genvar g = 0; g < NPICK; g++) begin : g_pick
    wp_oldest_pick #(.WAYS(WAYS), .AW(AW)) u_pick (
      .mask     (pick_mask[g]),
      .way_age  (way_age),
      .pick_way (pick_way[g]),
      .pick_any (pick_any[g])
    );
  end

  assign {free_any, free_way} = first_free(way_valid);

  // Empty way first, then the quota rule, then the whole set as a fallback.
  always_comb begin
    if (free_any)       grp = GRP_FREE;
    else if (quota_met) grp = pick_any[0] ? GRP_OWN   : GRP_ANY;
    else                grp = pick_any[1] ? GRP_OTHER : GRP_ANY;
  end

  always_comb begin
    unique case (grp)
      GRP_FREE:  miss_way = free_way;
      GRP_OWN:   miss_way = pick_way[0];
      GRP_OTHER: miss_way = pick_way[1];
      default:   miss_way = pick_way[2];
    endcase
  end

  assign victim_way = req_hit ? hit_way : miss_way;
  assign do_fill    = req_valid && !req_hit;

  wp_lru_update #(.WAYS(WAYS), .CIDW(CIDW), .AW(AW)) u_upd (
    .do_access (req_valid),
    .do_fill   (do_fill),
    .acc_way   (victim_way),
    .req_core  (req_core),
    .way_valid (way_valid),
    .way_owner (way_owner),
    .way_age   (way_age),
    .upd_valid (upd_valid),
    .upd_owner (upd_owner),
    .upd_age   (upd_age)
  );

  always_comb begin
    p_free_first_r2: assert (!(do_fill && free_any) || !way_valid[victim_way])
      else $error("valid line evicted while an empty way existed");
    p_take_other_r3: assert (!(do_fill && (grp == GRP_OTHER)) ||
                             (owner_of(way_owner, victim_way) != req_core))
      else $error("under quota but own line evicted");
    p_take_own_r4: assert (!(do_fill && (grp == GRP_OWN)) ||
                           (quota_met && (owner_of(way_owner, victim_way) == req_core)))
      else $error("at quota but foreign line evicted");
    p_fallback_r5: assert (grp != GRP_ANY ||
                           (pick_any[2] && (quota_met ? (own_mask == '0) : (other_mask == '0))))
      else $error("fallback used while chosen group had lines");
    p_hit_way_r8: assert (!(req_valid && req_hit) || (victim_way == hit_way))
      else $error("hit access not steered to hit way");
  end

endmodule

// File: tb/wp_victim_sel_test.sv
`timescale 1ns/1ps
module wp_victim_sel_test;
  localparam int WAYS = 16;
  localparam int CORES = 4;
  localparam int CIDW = 2;
  localparam int AW = 4;
  localparam int QW = 5;
  localparam int NV = 17;

  typedef struct packed {
    logic        act;
    logic        hit;
    logic [3:0]  hway;
    logic [15:0] vld;
    logic [31:0] own;
    logic [3:0]  rot;   // way w gets age (w+rot) mod 16
    logic [1:0]  req;
    logic [4:0]  quota;
    logic [3:0]  exp_way;
    logic [3:0]  tag;   // requirement exercised by the victim check
  } vec_t;

  // owner 32'hE4E4E4E4: core c holds ways c, c+4, c+8, c+12
  // owner 32'hAA555555: core 1 holds ways 0..11, core 2 holds 12..15
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 4'd0,  16'hFFFF, 32'hE4E4E4E4, 4'd0, 2'd0, 5'd5,  4'd15, 4'd3},
    '{1'b1, 1'b0, 4'd0,  16'hFFFF, 32'hE4E4E4E4, 4'd0, 2'd0, 5'd4,  4'd12, 4'd4},
    '{1'b1, 1'b0, 4'd0,  16'hFFFF, 32'hE4E4E4E4, 4'd0, 2'd0, 5'd3,  4'd12, 4'd4},
    '{1'b1, 1'b0, 4'd0,  16'hFFFF, 32'hE4E4E4E4, 4'd4, 2'd1, 5'd5,  4'd11, 4'd3},
    '{1'b1, 1'b0, 4'd0,  16'hFFFF, 32'hE4E4E4E4, 4'd4, 2'd2, 5'd4,  4'd10, 4'd4},
    '{1'b1, 1'b0, 4'd0,  16'hFFFF, 32'hAA555555, 4'd0, 2'd1, 5'd16, 4'd15, 4'd3},
    '{1'b1, 1'b0, 4'd0,  16'hFFFF, 32'hAA555555, 4'd0, 2'd1, 5'd12, 4'd11, 4'd4},
    '{1'b1, 1'b0, 4'd0,  16'hFFFF, 32'hAA555555, 4'd3, 2'd2, 5'd2,  4'd12, 4'd4},
    '{1'b1, 1'b0, 4'd0,  16'hFFFF, 32'hAA555555, 4'd3, 2'd0, 5'd1,  4'd12, 4'd3},
    '{1'b1, 1'b0, 4'd0,  16'hFFFF, 32'hAA555555, 4'd3, 2'd0, 5'd0,  4'd12, 4'd5},
    '{1'b1, 1'b0, 4'd0,  16'hFFFF, 32'hFFFFFFFF, 4'd5, 2'd3, 5'd20, 4'd10, 4'd5},
    '{1'b1, 1'b0, 4'd0,  16'h7F7F, 32'hE4E4E4E4, 4'd0, 2'd0, 5'd0,  4'd7,  4'd2},
    '{1'b1, 1'b0, 4'd0,  16'hFFFE, 32'hE4E4E4E4, 4'd9, 2'd2, 5'd16, 4'd0,  4'd2},
    '{1'b1, 1'b1, 4'd5,  16'hFFFF, 32'hE4E4E4E4, 4'd0, 2'd0, 5'd5,  4'd5,  4'd8},
    '{1'b1, 1'b1, 4'd0,  16'hFFFF, 32'hE4E4E4E4, 4'd0, 2'd3, 5'd1,  4'd0,  4'd8},
    '{1'b1, 1'b1, 4'd15, 16'hFFFF, 32'hE4E4E4E4, 4'd0, 2'd1, 5'd1,  4'd15, 4'd7},
    '{1'b0, 1'b0, 4'd0,  16'hFFFF, 32'hAA555555, 4'd7, 2'd1, 5'd4,  4'd0,  4'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic                 req_valid, req_hit;
  logic [AW-1:0]        hit_way;
  logic [CIDW-1:0]      req_core;
  logic [WAYS-1:0]      way_valid;
  logic [WAYS*CIDW-1:0] way_owner;
  logic [WAYS*AW-1:0]   way_age;
  logic [CORES*QW-1:0]  core_quota;
  logic [AW-1:0]        victim_way;
  logic [WAYS-1:0]      upd_valid;
  logic [WAYS*CIDW-1:0] upd_owner;
  logic [WAYS*AW-1:0]   upd_age;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  wp_victim_sel #(.WAYS(WAYS), .CORES(CORES)) uut (
    .req_valid (req_valid), .req_hit (req_hit), .hit_way (hit_way),
    .req_core (req_core), .way_valid (way_valid), .way_owner (way_owner),
    .way_age (way_age), .core_quota (core_quota), .victim_way (victim_way),
    .upd_valid (upd_valid), .upd_owner (upd_owner), .upd_age (upd_age)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [AW-1:0]        acc;
    logic [AW-1:0]        a_ref;
    logic [WAYS-1:0]      e_vld;
    logic [WAYS*CIDW-1:0] e_own;
    logic [WAYS*AW-1:0]   e_age;
    logic [WAYS*AW-1:0]   ages;
    logic                 fill;
    @(posedge clk);
    for (int w = 0; w < WAYS; w++) ages[w*AW +: AW] = AW'(w + int'(v.rot));
    for (int c = 0; c < CORES; c++)
      core_quota[c*QW +: QW] = (c == int'(v.req)) ? v.quota : 5'd1;
    req_valid = v.act; req_hit = v.hit; hit_way = v.hway; req_core = v.req;
    way_valid = v.vld; way_owner = v.own; way_age = ages;
    // independent expectation
    fill  = v.act && !v.hit;
    acc   = v.hit ? v.hway : v.exp_way;
    a_ref = ages[acc*AW +: AW];
    e_vld = v.vld; e_own = v.own; e_age = ages;
    if (v.act) begin
      for (int w = 0; w < WAYS; w++) begin
        logic [AW-1:0] a;
        a = ages[w*AW +: AW];
        if (w == int'(acc))   e_age[w*AW +: AW] = '0;
        else if (a < a_ref)   e_age[w*AW +: AW] = a + 4'd1;
      end
      if (fill) begin
        e_vld[acc] = 1'b1;
        e_own[acc*CIDW +: CIDW] = v.req;
      end
    end
    @(negedge clk);
    if (v.act)
      check(victim_way == v.exp_way, $sformatf("R%0d victim", v.tag),
            128'(victim_way), 128'(v.exp_way));
    if (!v.act)
      check({upd_valid, upd_owner, upd_age} == {e_vld, e_own, e_age}, "R1 idle hold",
            128'({upd_valid, upd_owner, upd_age}), 128'({e_vld, e_own, e_age}));
    else if (fill)
      check({upd_valid, upd_owner, upd_age} == {e_vld, e_own, e_age}, "R6 R7 fill update",
            128'({upd_valid, upd_owner, upd_age}), 128'({e_vld, e_own, e_age}));
    else
      check({upd_valid, upd_owner, upd_age} == {e_vld, e_own, e_age}, "R8 R7 hit update",
            128'({upd_valid, upd_owner, upd_age}), 128'({e_vld, e_own, e_age}));
  endtask

  initial begin
    req_valid = 1'b0; req_hit = 1'b0; hit_way = '0; req_core = '0;
    way_valid = '0; way_owner = '0; core_quota = '0;
    for (int w = 0; w < WAYS; w++) way_age[w*AW +: AW] = AW'(w);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset-like state: empty set, no access.
    @(negedge clk);
    check(upd_valid == '0 && upd_age == way_age, "R1 empty set held",
          128'({upd_valid, upd_age}), 128'({16'h0, way_age}));
    check(victim_way == '0, "R2 empty set victim", 128'(victim_way), 128'(0));
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    // Corner: empty ways and a quota that would point elsewhere (R2 over R4).
    run_vec('{1'b1, 1'b0, 4'd0, 16'hBFFF, 32'hFFFFFFFF, 4'd2, 2'd3, 5'd0, 4'd14, 4'd2});
    // Corner: hit on the most recent way of core 2, nothing ages (R7).
    run_vec('{1'b1, 1'b1, 4'd14, 16'hFFFF, 32'hAA555555, 4'd2, 2'd2, 5'd1, 4'd14, 4'd7});
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule